// File: doc/BRIEF.md
# Dice Game Instruction Executor

This block runs single 8-bit instructions for a small tabletop combat game. A strobe on `start_i` while the unit is idle copies `instr_i` into an instruction register. The unit then carries out one of three instruction kinds. A stat write stores a 5-bit value into a small stat memory. An attack roll adds a twenty-sided die to a stat modifier, compares the total with a stored armor class and sets the hit and crit flags. A damage roll, allowed only after a hit, rolls a chosen die, adds a strength or dexterity modifier, and rolls the die a second time on a crit.

Die values come from six free-running counters that step at different rates, so the value a roll picks up depends on when the instruction arrives. Each instruction ends in a wait state that holds the result until the downstream output sequencer pulses `seq_done_i`. The unit then goes back to idle and can accept the next instruction.

Top module: `dice_exec_unit`

## Requirements
- R1: After reset `busy_o`, `result_valid_o`, `hit_o` and `crit_o` are 0, `result_o` and `ir_o` are 0, and all eight stat memory entries read 0.
- R2: A high `start_i` seen at a clock edge while idle loads `instr_i` into `ir_o` and raises `busy_o` at that edge. While busy, `start_i` and `instr_i` are ignored and `ir_o` holds its value.
- R3: An instruction whose bits [7:5] are not 3'b111 is a stat write. It stores bits [4:0] into stat entry bits [7:5], produces no result (`result_valid_o` stays 0) and leaves the flags unchanged. Entry 6 holds the armor class. Entry 7 can never be written and reads 0.
- R4: Six die counters with codes 0..5 have 4, 6, 8, 10, 12 and 20 faces. Each starts at 1 after reset. Counter k advances once every k+1 clock edges and wraps from its face count back to 1. Die codes 6 and 7 give the value 0.
- R5: An attack roll is encoded 8'b1110_0aaa. One edge after latching it samples the 20-face counter into SUM and stat entry aaa into X. One edge later it sets `result_o` to SUM+X and raises `result_valid_o`. It sets `hit_o` when SUM+X is greater than or equal to entry 6, and otherwise clears `hit_o`.
- R6: When the sampled 20-face value of an attack roll is exactly 20, `hit_o` and `crit_o` are both set regardless of the modifier or the armor class. Otherwise `crit_o` is cleared.
- R7: An instruction 8'b1110_1xxx is a no-op. Flags, stat memory and `result_o` do not change, and `result_valid_o` stays 0. It still waits for `seq_done_i`.
- R8: A damage roll is encoded 8'b1111_sddd. When `hit_o` is set, it samples die code ddd one edge after latching and adds stat entry 1 (s=1) or entry 0 (s=0). Without crit the sum is the result two edges after latching. With crit, die ddd is sampled again on the third edge after latching and added in, and the result appears at that edge.
- R9: A damage roll with `hit_o` clear produces no result and clears both flags.
- R10: A damage roll that produces a result clears `hit_o` and `crit_o` at the same edge its result appears.
- R11: After any instruction the unit stays busy and holds `result_o` and `result_valid_o` until an edge with `seq_done_i` high. At that edge it returns to idle and `result_valid_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Instruction start strobe, taken only when idle |
| instr_i | input | 8 | Instruction word |
| seq_done_i | input | 1 | Output sequencer finished, releases the wait state |
| result_o | output | 8 | Last roll result |
| result_valid_o | output | 1 | Result of the current instruction is present |
| hit_o | output | 1 | Hit flag |
| crit_o | output | 1 | Critical flag |
| busy_o | output | 1 | An instruction is in progress |
| ir_o | output | 8 | Instruction register contents |

## Verification
A wrong die counter phase or a wrong stat memory entry shows up in `result_o` on the first roll that reads it. That is two or three edges after the start strobe, and the per-cycle model comparison catches it there. A wrong flag update shows up at once on `hit_o` or `crit_o`. It also shows up one instruction later, when a damage roll that should or should not produce a result does the opposite. A broken wait state appears on `busy_o` within one edge of `seq_done_i` being withheld or given. The natural-20 case is forced by timing the strobe against the modelled 20-face counter, so that the crit path with its second die sample is always covered.

// File: rtl/dice_exec_unit.sv
module dice_exec_unit #(
  parameter logic [2:0] AC_ADDR  = 3'd6,
  parameter logic [2:0] STR_ADDR = 3'd0,
  parameter logic [2:0] DEX_ADDR = 3'd1,
  parameter int         N_DICE   = 6,
  parameter int         DIV_W    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] instr_i,
  input  logic       seq_done_i,
  output logic [7:0] result_o,
  output logic       result_valid_o,
  output logic       hit_o,
  output logic       crit_o,
  output logic       busy_o,
  output logic [7:0] ir_o
);

  localparam int TOP_DIE = N_DICE - 1;

  typedef enum logic [2:0] {S_IDLE, S_EXEC, S_CMP, S_DADD, S_EXTRA, S_WAIT} state_t;

  function automatic int faces_of(int k);
    case (k)
      0: faces_of = 4;
      1: faces_of = 6;
      2: faces_of = 8;
      3: faces_of = 10;
      4: faces_of = 12;
      default: faces_of = 20;
    endcase
  endfunction

  state_t     st_q;
  logic [7:0] ir_q, sum_q, x_q, res_q;
  logic       valid_q, hit_q, crit_q;
  logic [4:0] mem_q [8];
  logic [4:0] die_val [N_DICE];
  logic [4:0] pick;

  for (genvar k = 0; k < N_DICE; k++) begin : g_die
    localparam logic [4:0] FACES = 5'(faces_of(k));
    logic [DIV_W-1:0] div_q;
    logic [4:0]       val_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        div_q <= '0;
        val_q <= 5'd1;
      end else if (div_q == DIV_W'(k)) begin
        div_q <= '0;
        val_q <= (val_q == FACES) ? 5'd1 : val_q + 5'd1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
    assign die_val[k] = val_q;

    assert_die_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q >= 5'd1) && (val_q <= FACES));
  end

  always_comb begin
    case (ir_q[2:0])
      3'd0: pick = die_val[0];
      3'd1: pick = die_val[1];
      3'd2: pick = die_val[2];
      3'd3: pick = die_val[3];
      3'd4: pick = die_val[4];
      3'd5: pick = die_val[5];
      default: pick = 5'd0;
    endcase
  end

  wire       is_stat  = ir_q[7:5] != 3'b111;
  wire       is_roll  = ir_q[7:4] == 4'b1110;
  wire [2:0] dmg_addr = ir_q[3] ? DEX_ADDR : STR_ADDR;
  wire [7:0] total    = sum_q + x_q;
  wire       nat20    = sum_q == 8'd20;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      ir_q    <= '0;
      sum_q   <= '0;
      x_q     <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      crit_q  <= 1'b0;
      for (int i = 0; i < 8; i++) mem_q[i] <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          ir_q    <= instr_i;
          valid_q <= 1'b0;
          st_q    <= S_EXEC;
        end
        S_EXEC: begin
          if (is_stat) begin
            mem_q[ir_q[7:5]] <= ir_q[4:0];
            st_q <= S_WAIT;
          end else if (is_roll) begin
            if (ir_q[3]) begin
              st_q <= S_WAIT;
            end else begin
              sum_q <= {3'b000, die_val[TOP_DIE]};
              x_q   <= {3'b000, mem_q[ir_q[2:0]]};
              st_q  <= S_CMP;
            end
          end else if (hit_q) begin
            sum_q <= {3'b000, pick};
            x_q   <= {3'b000, mem_q[dmg_addr]};
            st_q  <= S_DADD;
          end else begin
            hit_q  <= 1'b0;
            crit_q <= 1'b0;
            st_q   <= S_WAIT;
          end
        end
        S_CMP: begin
          res_q   <= total;
          valid_q <= 1'b1;
          crit_q  <= nat20;
          hit_q   <= nat20 || (total >= {3'b000, mem_q[AC_ADDR]});
          st_q    <= S_WAIT;
        end
        S_DADD: begin
          sum_q <= total;
          if (crit_q) begin
            st_q <= S_EXTRA;
          end else begin
            res_q   <= total;
            valid_q <= 1'b1;
            hit_q   <= 1'b0;
            crit_q  <= 1'b0;
            st_q    <= S_WAIT;
          end
        end
        S_EXTRA: begin
          res_q   <= sum_q + {3'b000, pick};
          valid_q <= 1'b1;
          hit_q   <= 1'b0;
          crit_q  <= 1'b0;
          st_q    <= S_WAIT;
        end
        S_WAIT: if (seq_done_i) begin
          valid_q <= 1'b0;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign result_o       = res_q;
  assign result_valid_o = valid_q;
  assign hit_o          = hit_q;
  assign crit_o         = crit_q;
  assign busy_o         = st_q != S_IDLE;
  assign ir_o           = ir_q;

  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(st_q == S_WAIT && seq_done_i)) |=> $stable(ir_q));

  assert_stat_no_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_EXEC && is_stat) |=> (!valid_q && $stable(hit_q) && $stable(crit_q)));

  assert_crit_implies_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    crit_q |-> hit_q);

  assert_noop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_EXEC && is_roll && ir_q[3]) |=> ($stable(hit_q) && $stable(crit_q) && $stable(res_q) && !valid_q));

  assert_miss_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_EXEC && !is_stat && !is_roll && !hit_q) |=> (!hit_q && !crit_q && !valid_q));

  assert_damage_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_EXTRA) |=> (!hit_q && !crit_q && valid_q));

  assert_wait_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && !seq_done_i) |=> (st_q == S_WAIT && $stable(res_q) && $stable(valid_q)));

endmodule

// File: tb/dice_exec_unit_tb.sv
module dice_exec_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] instr_i = 8'h00;
  logic       seq_done_i = 1'b0;
  logic [7:0] result_o, ir_o;
  logic       result_valid_o, hit_o, crit_o, busy_o;

  always #10 clk = ~clk;

  dice_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
    .seq_done_i(seq_done_i), .result_o(result_o), .result_valid_o(result_valid_o),
    .hit_o(hit_o), .crit_o(crit_o), .busy_o(busy_o), .ir_o(ir_o)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  int ms, msum, mx, mres, mvalid, mhit, mcrit;
  logic [7:0] mir;
  int mm [8];
  int dv [6];
  int dd [6];
  int faces [6] = '{4, 6, 8, 10, 12, 20};

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    ms = 0; msum = 0; mx = 0; mres = 0; mvalid = 0; mhit = 0; mcrit = 0; mir = 8'h00;
    for (int i = 0; i < 8; i++) mm[i] = 0;
    for (int k = 0; k < 6; k++) begin dv[k] = 1; dd[k] = 0; end
  endtask

  task automatic model_edge();
    int pick;
    pick = (mir[2:0] < 3'd6) ? dv[mir[2:0]] : 0;
    case (ms)
      0: if (start_i) begin mir = instr_i; mvalid = 0; ms = 1; end
      1: begin
        if (mir[7:5] != 3'b111) begin
          mm[mir[7:5]] = mir[4:0]; ms = 5;
        end else if (mir[4] == 1'b0) begin
          if (mir[3]) ms = 5;
          else begin msum = dv[5]; mx = mm[mir[2:0]]; ms = 2; end
        end else if (mhit != 0) begin
          msum = pick; mx = mm[mir[3] ? 1 : 0]; ms = 3;
        end else begin
          mhit = 0; mcrit = 0; ms = 5;
        end
      end
      2: begin
        mres = (msum + mx) % 256; mvalid = 1;
        mcrit = (msum == 20);
        mhit = (msum == 20) || (msum + mx >= mm[6]);
        ms = 5;
      end
      3: begin
        msum = msum + mx;
        if (mcrit != 0) ms = 4;
        else begin mres = msum; mvalid = 1; mhit = 0; mcrit = 0; ms = 5; end
      end
      4: begin mres = msum + pick; mvalid = 1; mhit = 0; mcrit = 0; ms = 5; end
      5: if (seq_done_i) begin mvalid = 0; ms = 0; end
      default: ms = 0;
    endcase
    for (int k = 0; k < 6; k++) begin
      if (dd[k] == k) begin dd[k] = 0; dv[k] = (dv[k] == faces[k]) ? 1 : dv[k] + 1; end
      else dd[k] = dd[k] + 1;
    end
  endtask

  task automatic compare();
    chk(tag, "result_o", result_o, mres);
    chk(tag, "result_valid_o", result_valid_o, mvalid);
    chk(tag, "hit_o", hit_o, mhit);
    chk(tag, "crit_o", crit_o, mcrit);
    chk(tag, "busy_o", busy_o, ms != 0);
    chk(tag, "ir_o", ir_o, mir);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(logic [7:0] ins, int done_delay, logic [7:0] noise);
    start_i = 1'b1; instr_i = ins;
    step();
    instr_i = noise;
    while (ms != 5) step();
    for (int i = 0; i < done_delay; i++) step();
    start_i = 1'b0;
    seq_done_i = 1'b1;
    step();
    seq_done_i = 1'b0;
  endtask

  task automatic wait_nat20();
    int nxt;
    for (int i = 0; i < 200; i++) begin
      nxt = (dd[5] == 5) ? ((dv[5] == 20) ? 1 : dv[5] + 1) : dv[5];
      if (nxt == 20) break;
      step();
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("R1", "busy_o", busy_o, 0);
    chk("R1", "result_valid_o", result_valid_o, 0);
    chk("R1", "hit_o", hit_o, 0);
    chk("R1", "crit_o", crit_o, 0);
    chk("R1", "result_o", result_o, 0);
    chk("R1", "ir_o", ir_o, 0);
    model_edge();
    repeat (2) step();

    tag = "R1";
    run(8'hE3, 0, 8'h00);
    chk("R1", "attack with zero memory hits when total >= 0", hit_o, 1);

    tag = "R3";
    run(8'h05, 0, 8'h00);
    run(8'h2C, 2, 8'h00);
    run(8'h5F, 0, 8'h00);
    run(8'hCF, 1, 8'h00);
    run(8'h67, 0, 8'h00);
    chk("R3", "no result after stat write", result_valid_o, 0);

    tag = "R2";
    run(8'h83, 3, 8'hE0);
    chk("R2", "ir_o ignores instr while busy", ir_o, 8'h83);

    tag = "R5";
    for (int n = 0; n < 5; n++) begin
      run(8'hE0 | 8'(n % 4), n % 3, 8'hFF);
      tag = "R8";
      run(8'hF0 | 8'(n), 1, 8'h11);
      tag = "R5";
    end

    tag = "R4";
    for (int n = 0; n < 8; n++) begin
      run(8'hE2, 0, 8'h00);
      run(8'hF8 | 8'(n), 0, 8'h00);
      repeat (n + 1) step();
    end

    tag = "R9";
    run(8'hF5, 0, 8'h00);
    run(8'hF5, 0, 8'h00);
    chk("R9", "hit_o after damage", hit_o, 0);
    chk("R9", "no result", result_valid_o, 0);

    tag = "R6";
    run(8'hDF, 0, 8'h00);
    wait_nat20();
    run(8'hE7, 0, 8'h00);
    chk("R6", "natural 20 result", result_o, 20);
    chk("R6", "natural 20 hit", hit_o, 1);
    chk("R6", "natural 20 crit", crit_o, 1);

    tag = "R7";
    run(8'hE8, 2, 8'h00);
    chk("R7", "no-op keeps crit", crit_o, 1);
    chk("R7", "no-op keeps result", result_o, 20);

    tag = "R10";
    run(8'hFD, 0, 8'h00);
    chk("R10", "hit cleared after crit damage", hit_o, 0);
    chk("R10", "crit cleared after crit damage", crit_o, 0);

    tag = "R8";
    for (int n = 0; n < 4; n++) begin
      wait_nat20();
      run(8'hE1, 0, 8'h00);
      repeat (n * 2) step();
      run(8'hF0 | 8'(n + 2), n, 8'h00);
    end

    tag = "R11";
    run(8'hE0, 9, 8'h00);
    chk("R11", "valid held then released", result_valid_o, 0);
    chk("R11", "idle after done", busy_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule